// File: doc/BRIEF.md
# Storage key reference/change updater

This block keeps one small key per page of a modest absolute memory. Each key records whether the page has been referenced and whether it has been changed. It also holds an access-control nibble and a fetch-protect bit that software places there. Every translated access (a load, a store or an instruction fetch) is handed to the block with its absolute address and the permission flags the translation produced. The block looks up the page's key, sets the reference bit, and sets the change bit if the access is a store. It writes the key back only when the value actually changed, and then returns the permission flags.

For loads and fetches, the block withholds write permission while the page's change bit is still clear. A caller that caches the returned flags therefore cannot perform a later store silently: that first store has to come back through the updater, and the change bit gets recorded. Until software has written a key for the first time, the facility stays off and accesses pass through untouched. A separate set/get port gives direct access to the keys.

Top module: `skey_updater`

## Requirements
- R1: After reset `acc_ready` is 1, `rsp_valid` and `key_wr` are 0, every key reads back as 0, and the facility is off.
- R2: A request is accepted on a rising edge where `acc_valid` and `acc_ready` are both 1. `acc_ready` then stays 0 for three cycles. `rsp_valid` is 1 for exactly the third of those cycles, which is the cycle that follows the key write-back.
- R3: While the facility is off, `rsp_flags` equals the accepted `acc_flags` and no key changes.
- R4: The key index is `acc_addr >> PAGE_BITS`. An index at or above `MEM_PAGES` counts as a failed key lookup: flags are returned unchanged, no key is written, and a get of that index returns 0.
- R5: When the facility is on, every in-range access sets key bit 2 (reference).
- R6: An in-range store with the facility on sets key bit 1 (change) and returns its flags unchanged. `acc_kind` uses 2'b00 for a load, 2'b01 for a store, and 2'b10 or 2'b11 for a fetch.
- R7: For a load or fetch with the facility on and the change bit clear in the key as read, flag bit 1 (write) is cleared. Flag bits 0 (read) and 2 (execute) are never altered, and no flag bit is ever set.
- R8: A key is written back only when the updated value differs from the value read. `key_wr` is 1 for exactly the cycle in which such a write-back happens, which is the cycle just before `rsp_valid`.
- R9: A pulse on `sk_set` stores `sk_wkey` into page `sk_addr >> PAGE_BITS` (if that page is in range) at the next edge and turns the facility on permanently. A pulse on `sk_get` makes `sk_rvalid` 1 in the next cycle, with `sk_rkey` showing the key as it stood before any set made in the same cycle.
- R10: A set that lands in the write-back cycle on the page under update wins, and the access write is dropped. A set that lands in the lookup cycle on that page becomes the value the update builds on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access request present |
| acc_ready | output | 1 | Updater idle, request can be taken |
| acc_kind | input | 2 | 00 load, 01 store, 1x fetch |
| acc_addr | input | ADDR_W | Absolute address of the access |
| acc_flags | input | 3 | Permission flags in: bit0 read, bit1 write, bit2 execute |
| rsp_valid | output | 1 | Response cycle |
| rsp_flags | output | 3 | Permission flags out, same layout |
| key_wr | output | 1 | A key write-back by the access path this cycle |
| sk_set | input | 1 | Store `sk_wkey` into the addressed page key |
| sk_get | input | 1 | Read the addressed page key |
| sk_addr | input | ADDR_W | Absolute address selecting the page for set/get |
| sk_wkey | input | 7 | Key to store: [6:3] access control, [2] reference, [1] change, [0] fetch protect |
| sk_rvalid | output | 1 | `sk_rkey` valid |
| sk_rkey | output | 7 | Key read back |

## Verification
A corrupted key shows up at the ports within three cycles in one of two ways: the next access to that page returns the wrong write flag or pulses `key_wr` when it should not, or the next get on that page returns the wrong key. A stuck enable flag is exposed on the first access to a page whose key was never set, because that access either narrows its flags or leaves them alone. A sequencer that loses its place changes when `acc_ready` and `rsp_valid` appear, and the bench compares both on every cycle. Collisions between a set and an update are only visible in the key that remains, so each collision is followed by a get of that page.

// File: rtl/skey_pkg.sv
package skey_pkg;

  localparam int KEY_W   = 7;
  localparam int FLAG_W  = 3;
  localparam int REF_BIT = 2;
  localparam int CHG_BIT = 1;
  localparam int WR_FLAG = 1;

  localparam logic [1:0] KIND_LOAD  = 2'b00;
  localparam logic [1:0] KIND_STORE = 2'b01;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOOK,
    ST_COMMIT,
    ST_RESP
  } seq_st_e;

  // Key after an access: reference always, change only on a store.
  function automatic logic [KEY_W-1:0] key_touch(input logic is_store,
                                                 input logic [KEY_W-1:0] k);
    logic [KEY_W-1:0] r;
    r = k;
    r[REF_BIT] = 1'b1;
    if (is_store) r[CHG_BIT] = 1'b1;
    return r;
  endfunction

  // Flags after an access: non-stores lose write until change is recorded.
  function automatic logic [FLAG_W-1:0] flags_narrow(input logic is_store,
                                                     input logic [KEY_W-1:0] k,
                                                     input logic [FLAG_W-1:0] f);
    logic [FLAG_W-1:0] r;
    r = f;
    if (!is_store && !k[CHG_BIT]) r[WR_FLAG] = 1'b0;
    return r;
  endfunction

endpackage

// File: rtl/skey_array.sv
module skey_array
  import skey_pkg::*;
#(
  parameter int IDX_W     = 4,
  parameter int MEM_PAGES = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [KEY_W-1:0] rd_key,
  input  logic             upd_we,
  input  logic [IDX_W-1:0] upd_idx,
  input  logic [KEY_W-1:0] upd_key,
  input  logic             set_we,
  input  logic [IDX_W-1:0] set_idx,
  input  logic [KEY_W-1:0] set_key,
  input  logic             get_re,
  input  logic [IDX_W-1:0] get_idx,
  output logic             get_valid,
  output logic [KEY_W-1:0] get_key
);

  logic [KEY_W-1:0] keys [MEM_PAGES];
  logic [KEY_W-1:0] get_mux;

  for (genvar i = 0; i < MEM_PAGES; i++) begin : g_slot
    logic hit_set, hit_upd;
    assign hit_set = set_we && (set_idx == IDX_W'(i));
    assign hit_upd = upd_we && (upd_idx == IDX_W'(i));
    always_ff @(posedge clk) begin
      if (!rst_n)       keys[i] <= '0;
      else if (hit_set) keys[i] <= set_key;
      else if (hit_upd) keys[i] <= upd_key;
    end
  end

  // Absent pages read as zero.
  always_comb begin
    rd_key  = '0;
    get_mux = '0;
    for (int i = 0; i < MEM_PAGES; i++) begin
      if (rd_idx == IDX_W'(i))  rd_key  = keys[i];
      if (get_idx == IDX_W'(i)) get_mux = keys[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      get_valid <= 1'b0;
      get_key   <= '0;
    end else begin
      get_valid <= get_re;
      if (get_re) get_key <= get_mux;
    end
  end

endmodule

// File: rtl/skey_seq.sv
module skey_seq
  import skey_pkg::*;
#(
  parameter int IDX_W     = 4,
  parameter int MEM_PAGES = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  output logic              acc_ready,
  input  logic [1:0]        acc_kind,
  input  logic [IDX_W-1:0]  acc_idx,
  input  logic [FLAG_W-1:0] acc_flags,
  output logic [IDX_W-1:0]  rd_idx,
  input  logic [KEY_W-1:0]  rd_key,
  input  logic              set_pulse,
  input  logic [IDX_W-1:0]  set_idx,
  input  logic [KEY_W-1:0]  set_key,
  output logic              upd_we,
  output logic [IDX_W-1:0]  upd_idx,
  output logic [KEY_W-1:0]  upd_key,
  output logic              rsp_valid,
  output logic [FLAG_W-1:0] rsp_flags,
  output logic              ev_commit,
  output logic              ev_collide
);

  localparam logic [IDX_W:0] LIMIT = (IDX_W+1)'(MEM_PAGES);

  seq_st_e           st;
  logic              enabled;
  logic              store_q;
  logic [IDX_W-1:0]  idx_q;
  logic [FLAG_W-1:0] flags_q;
  logic [KEY_W-1:0]  key_q;
  logic              en_q;
  logic [FLAG_W-1:0] rsp_q;

  logic             in_range;
  logic             same_pg;
  logic             active;
  logic [KEY_W-1:0] new_key;

  assign in_range  = {1'b0, idx_q} < LIMIT;
  assign same_pg   = set_pulse && (set_idx == idx_q);
  assign active    = en_q && in_range;
  assign new_key   = key_touch(store_q, key_q);
  assign ev_commit = (st == ST_COMMIT);
  assign ev_collide = ev_commit && same_pg;

  assign upd_we  = ev_commit && active && (new_key != key_q) && !same_pg;
  assign upd_idx = idx_q;
  assign upd_key = new_key;
  assign rd_idx  = idx_q;

  assign acc_ready = (st == ST_IDLE);
  assign rsp_valid = (st == ST_RESP);
  assign rsp_flags = rsp_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      enabled <= 1'b0;
      store_q <= 1'b0;
      idx_q   <= '0;
      flags_q <= '0;
      key_q   <= '0;
      en_q    <= 1'b0;
      rsp_q   <= '0;
    end else begin
      if (set_pulse) enabled <= 1'b1;
      unique case (st)
        ST_IDLE: begin
          if (acc_valid) begin
            store_q <= (acc_kind == KIND_STORE);
            idx_q   <= acc_idx;
            flags_q <= acc_flags;
            st      <= ST_LOOK;
          end
        end
        ST_LOOK: begin
          key_q <= same_pg ? set_key : rd_key;
          en_q  <= enabled || set_pulse;
          st    <= ST_COMMIT;
        end
        ST_COMMIT: begin
          rsp_q <= active ? flags_narrow(store_q, key_q, flags_q) : flags_q;
          st    <= ST_RESP;
        end
        ST_RESP: st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/skey_updater.sv
module skey_updater
  import skey_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int PAGE_BITS = 12,
  parameter int MEM_PAGES = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  output logic              acc_ready,
  input  logic [1:0]        acc_kind,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [2:0]        acc_flags,
  output logic              rsp_valid,
  output logic [2:0]        rsp_flags,
  output logic              key_wr,
  input  logic              sk_set,
  input  logic              sk_get,
  input  logic [ADDR_W-1:0] sk_addr,
  input  logic [6:0]        sk_wkey,
  output logic              sk_rvalid,
  output logic [6:0]        sk_rkey
);

  localparam int IDX_W = ADDR_W - PAGE_BITS;

  function automatic logic [IDX_W-1:0] page_of(input logic [ADDR_W-1:0] a);
    return IDX_W'(a >> PAGE_BITS);
  endfunction

  logic [IDX_W-1:0] acc_idx, sk_idx, rd_idx, upd_idx;
  logic [KEY_W-1:0] rd_key, upd_key;
  logic             upd_we;
  logic             ev_commit, ev_collide;

  assign acc_idx = page_of(acc_addr);
  assign sk_idx  = page_of(sk_addr);
  assign key_wr  = upd_we;

  skey_seq #(.IDX_W(IDX_W), .MEM_PAGES(MEM_PAGES)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .acc_valid(acc_valid), .acc_ready(acc_ready), .acc_kind(acc_kind),
    .acc_idx(acc_idx), .acc_flags(acc_flags),
    .rd_idx(rd_idx), .rd_key(rd_key),
    .set_pulse(sk_set), .set_idx(sk_idx), .set_key(sk_wkey),
    .upd_we(upd_we), .upd_idx(upd_idx), .upd_key(upd_key),
    .rsp_valid(rsp_valid), .rsp_flags(rsp_flags),
    .ev_commit(ev_commit), .ev_collide(ev_collide)
  );

  skey_array #(.IDX_W(IDX_W), .MEM_PAGES(MEM_PAGES)) u_keys (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(rd_idx), .rd_key(rd_key),
    .upd_we(upd_we), .upd_idx(upd_idx), .upd_key(upd_key),
    .set_we(sk_set), .set_idx(sk_idx), .set_key(sk_wkey),
    .get_re(sk_get), .get_idx(sk_idx),
    .get_valid(sk_rvalid), .get_key(sk_rkey)
  );

endmodule

// File: rtl/skey_updater_chk.sv
module skey_updater_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       acc_valid,
  input logic       acc_ready,
  input logic [1:0] acc_kind,
  input logic [2:0] acc_flags,
  input logic       rsp_valid,
  input logic [2:0] rsp_flags,
  input logic       key_wr,
  input logic       sk_get,
  input logic       sk_rvalid,
  input logic       ev_commit,
  input logic       ev_collide
);

  // R2
  accept_to_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && acc_ready |=> !acc_ready ##2 rsp_valid);

  // R2
  rsp_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid && acc_ready);

  // R7
  flags_no_widen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_flags & ~$past(acc_flags, 3)) == 3'b000);

  // R7
  flags_rx_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_flags[0] == $past(acc_flags[0], 3) &&
                  rsp_flags[2] == $past(acc_flags[2], 3));

  // R6
  store_flags_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && $past(acc_kind, 3) == 2'b01 |-> rsp_flags == $past(acc_flags, 3));

  // R8
  wr_in_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    key_wr |-> ev_commit);

  // R8
  wr_before_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    key_wr |=> rsp_valid);

  // R10
  collide_blocks_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_collide |-> !key_wr);

  // R9
  get_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sk_get |=> sk_rvalid);

endmodule

bind skey_updater skey_updater_chk u_chk (
  .clk(clk), .rst_n(rst_n),
  .acc_valid(acc_valid), .acc_ready(acc_ready), .acc_kind(acc_kind),
  .acc_flags(acc_flags), .rsp_valid(rsp_valid), .rsp_flags(rsp_flags),
  .key_wr(key_wr), .sk_get(sk_get), .sk_rvalid(sk_rvalid),
  .ev_commit(ev_commit), .ev_collide(ev_collide)
);

// File: tb/tb_skey_updater.sv
module tb_skey_updater;

  localparam int CLK_PERIOD = 10;
  localparam int AW  = 16;
  localparam int PB  = 12;
  localparam int MP  = 12;
  localparam int NPG = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          acc_valid = 1'b0;
  logic          acc_ready;
  logic [1:0]    acc_kind = '0;
  logic [AW-1:0] acc_addr = '0;
  logic [2:0]    acc_flags = '0;
  logic          rsp_valid;
  logic [2:0]    rsp_flags;
  logic          key_wr;
  logic          sk_set = 1'b0;
  logic          sk_get = 1'b0;
  logic [AW-1:0] sk_addr = '0;
  logic [6:0]    sk_wkey = '0;
  logic          sk_rvalid;
  logic [6:0]    sk_rkey;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  skey_updater #(.ADDR_W(AW), .PAGE_BITS(PB), .MEM_PAGES(MP)) dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  logic [6:0] m_key [NPG];
  bit         m_en;
  int         m_ph;      // 0 idle, then phases 1..3 after acceptance
  bit         m_store;
  int         m_pg;
  logic [2:0] m_fl;
  logic [6:0] m_snap;
  bit         m_snap_en;
  logic [2:0] m_rsp;
  bit         m_rv;
  logic [6:0] m_rk;

  function automatic int pg_of(input logic [AW-1:0] a);
    return int'(a) / (1 << PB);
  endfunction

  function automatic logic [6:0] touched(input logic [6:0] k, input bit st);
    return k | 7'h04 | (st ? 7'h02 : 7'h00);
  endfunction

  function automatic bit m_live();
    return m_snap_en && (m_pg < MP);
  endfunction

  function automatic bit exp_wr();
    bit clash;
    clash = sk_set && (pg_of(sk_addr) == m_pg);
    return (m_ph == 2) && m_live() && (touched(m_snap, m_store) != m_snap) && !clash;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NPG; i++) m_key[i] = '0;
      m_en = 0; m_ph = 0; m_rv = 0; m_rk = '0; m_rsp = '0;
    end else begin
      int sp;
      sp = pg_of(sk_addr);
      m_rv = sk_get;
      if (sk_get) m_rk = (sp < MP) ? m_key[sp] : 7'h00;
      case (m_ph)
        0: if (acc_valid) begin
             m_store = (acc_kind == 2'b01);
             m_pg = pg_of(acc_addr);
             m_fl = acc_flags;
             m_ph = 1;
           end
        1: begin
             if (sk_set && sp == m_pg) m_snap = sk_wkey;
             else m_snap = (m_pg < MP) ? m_key[m_pg] : 7'h00;
             m_snap_en = m_en || sk_set;
             m_ph = 2;
           end
        2: begin
             if (exp_wr()) m_key[m_pg] = touched(m_snap, m_store);
             m_rsp = m_fl;
             if (m_live() && !m_store && !m_snap[1]) m_rsp[1] = 1'b0;
             m_ph = 3;
           end
        default: m_ph = 0;
      endcase
      if (sk_set) begin
        m_en = 1;
        if (sp < MP) m_key[sp] = sk_wkey;
      end
    end
  end

  // Every-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk(acc_ready == (m_ph == 0), "R2 acc_ready", acc_ready, m_ph == 0);
      chk(rsp_valid == (m_ph == 3), "R2 rsp_valid", rsp_valid, m_ph == 3);
      if (m_ph == 3) chk(rsp_flags == m_rsp, "R7 rsp_flags", rsp_flags, m_rsp);
      chk(key_wr == exp_wr(), "R8 key_wr", key_wr, exp_wr());
      chk(sk_rvalid == m_rv, "R9 sk_rvalid", sk_rvalid, m_rv);
      if (m_rv) chk(sk_rkey == m_rk, "R9 sk_rkey", sk_rkey, m_rk);
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic acc_start(input logic [1:0] k, input int pg, input logic [2:0] f);
    while (!acc_ready) step();
    acc_valid = 1'b1; acc_kind = k; acc_addr = AW'(pg * (1 << PB) + 'h2a); acc_flags = f;
    step();
    acc_valid = 1'b0;
  endtask

  task automatic wait_rsp(output logic [2:0] f, output bit wr);
    wr = 0;
    forever begin
      @(negedge clk);
      if (key_wr) wr = 1;
      if (rsp_valid) begin f = rsp_flags; break; end
    end
    step();
  endtask

  task automatic do_acc(input logic [1:0] k, input int pg, input logic [2:0] f,
                        output logic [2:0] rf, output bit wr);
    acc_start(k, pg, f);
    wait_rsp(rf, wr);
  endtask

  task automatic set_key(input int pg, input logic [6:0] kv);
    sk_set = 1'b1; sk_addr = AW'(pg * (1 << PB) + 'h100); sk_wkey = kv;
    step();
    sk_set = 1'b0;
  endtask

  task automatic get_key(input int pg, output logic [6:0] kv);
    sk_get = 1'b1; sk_addr = AW'(pg * (1 << PB) + 'hff0);
    step();
    sk_get = 1'b0;
    @(negedge clk);
    kv = sk_rkey;
    step();
  endtask

  initial begin : watchdog
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=%0d expected<=150000", cyc);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
      end
    end
  end

  initial begin : stim
    logic [2:0] rf;
    logic [6:0] kv;
    bit wr;
    repeat (3) step();
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(acc_ready == 1'b1, "R1 ready", acc_ready, 1);
    chk(rsp_valid == 1'b0 && key_wr == 1'b0, "R1 idle outputs", {rsp_valid, key_wr}, 0);
    step();
    get_key(0, kv);
    chk(kv == 7'h00, "R1 key0", kv, 0);

    // R3 facility off
    do_acc(2'b00, 2, 3'b111, rf, wr);
    chk(rf == 3'b111, "R3 flags off", rf, 3'b111);
    chk(!wr, "R3 no write", wr, 0);
    get_key(2, kv);
    chk(kv == 7'h00, "R3 key untouched", kv, 0);

    // R9 set enables facility
    set_key(5, 7'h50);
    get_key(5, kv);
    chk(kv == 7'h50, "R9 set/get", kv, 7'h50);

    // R5 R7 load with change clear
    do_acc(2'b00, 5, 3'b111, rf, wr);
    chk(rf == 3'b101, "R7 load narrows", rf, 3'b101);
    chk(wr, "R5 ref written", wr, 1);
    get_key(5, kv);
    chk(kv == 7'h54, "R5 ref bit", kv, 7'h54);

    // R8 no write when unchanged
    do_acc(2'b10, 5, 3'b110, rf, wr);
    chk(!wr, "R8 no redundant write", wr, 0);
    chk(rf == 3'b100, "R7 fetch narrows", rf, 3'b100);

    // R6 store
    do_acc(2'b01, 5, 3'b011, rf, wr);
    chk(rf == 3'b011, "R6 store flags", rf, 3'b011);
    get_key(5, kv);
    chk(kv == 7'h56, "R6 change bit", kv, 7'h56);
    do_acc(2'b11, 5, 3'b111, rf, wr);
    chk(rf == 3'b111, "R7 change set keeps write", rf, 3'b111);

    // R4 absent page
    do_acc(2'b00, 14, 3'b111, rf, wr);
    chk(rf == 3'b111 && !wr, "R4 failed lookup", {rf, wr}, 4'b1110);
    get_key(14, kv);
    chk(kv == 7'h00, "R4 absent reads zero", kv, 0);

    // R10 set in write-back cycle wins
    set_key(1, 7'h00);
    acc_start(2'b01, 1, 3'b111);
    step();
    sk_set = 1'b1; sk_addr = AW'(1 * (1 << PB)); sk_wkey = 7'h78;
    @(negedge clk);
    chk(!key_wr, "R10 commit clash no write", key_wr, 0);
    step();
    sk_set = 1'b0;
    wait_rsp(rf, wr);
    get_key(1, kv);
    chk(kv == 7'h78, "R10 set wins", kv, 7'h78);

    // R10 set in lookup cycle is built upon
    acc_start(2'b00, 3, 3'b111);
    sk_set = 1'b1; sk_addr = AW'(3 * (1 << PB)); sk_wkey = 7'h08;
    step();
    sk_set = 1'b0;
    wait_rsp(rf, wr);
    chk(rf == 3'b101, "R10 lookup forward flags", rf, 3'b101);
    get_key(3, kv);
    chk(kv == 7'h0c, "R10 lookup forward key", kv, 7'h0c);

    // R9 get and set in same cycle returns old value
    sk_set = 1'b1; sk_get = 1'b1; sk_addr = AW'(3 * (1 << PB)); sk_wkey = 7'h33;
    step();
    sk_set = 1'b0; sk_get = 1'b0;
    @(negedge clk);
    chk(sk_rkey == 7'h0c, "R9 get sees old", sk_rkey, 7'h0c);
    step();

    // Mixed traffic, checked against the model every cycle
    for (int n = 0; n < 3000; n++) begin
      int pa, ps;
      pa = ($urandom % 6 == 0) ? 12 + $urandom % 4 : $urandom % 4;
      ps = ($urandom % 6 == 0) ? 12 + $urandom % 4 : $urandom % 4;
      acc_valid = ($urandom % 3 == 0);
      acc_kind  = 2'($urandom);
      acc_addr  = AW'(pa * (1 << PB) + $urandom % (1 << PB));
      acc_flags = 3'($urandom);
      sk_set    = ($urandom % 9 == 0);
      sk_get    = ($urandom % 4 == 0);
      sk_addr   = AW'(ps * (1 << PB) + $urandom % (1 << PB));
      sk_wkey   = 7'($urandom) & 7'h79;
      step();
    end
    acc_valid = 1'b0; sk_set = 1'b0; sk_get = 1'b0;
    repeat (6) step();

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule